// File: doc/BRIEF.md
# Timer Channel Status Flag Register

This block is the 8-bit status register of one 16-bit up/down timer channel. Single-cycle event pulses from the timer core set six sticky flags: counter underflow, counter overflow, and four compare/capture match events. The register also reports the direction in which the counter is currently running. Each flag drives a level interrupt request, and a per-flag enable input gates that request. Software reads the register over a simple strobe interface and clears flags by writing zeros.

A flag clears only through a two-step handshake. Software must first read the register while that flag is 1. This arms the flag. The next write to the register then clears every armed flag whose bit is written as 0. Any write uses up all the arming, whatever value it carries. This rule means software cannot clear an event it has never seen. If a flag was 0 when it was read and an event then sets it, a later write of 0 does not clear it.

The parameter `PHASE_CAPABLE` states whether the channel supports phase counting. When it is 0, the direction bit and the underflow flag become fixed reserved bits. The direction bit reads 1, the underflow flag reads 0, and the matching inputs have no effect.

Top module: `tmr_flag_reg`

## Requirements
- R1: On reset, `rd_data` reads 0xC0. All six flags and all arming are clear, and the direction bit reads 1.
- R2: Bit 6 of `rd_data` always reads 1, and no write changes it.
- R3: When `PHASE_CAPABLE`=1, bit 7 of `rd_data` shows the value of `dir_up` (1 = counting up) taken at the previous rising clock edge. It cannot be written.
- R4: A one-cycle event pulse sets its flag, and the flag reads 1 from the next cycle on. The field positions are fixed: bit 5 is `evt_udf`, bit 4 is `evt_ovf`, bit 3 is `evt_cmp[3]` (D), bit 2 is C, bit 1 is B and bit 0 is `evt_cmp[0]` (A).
- R5: A flag that was read as 1 and is then written with 0 on the next register write is clear from the cycle after that write.
- R6: A write of 0 to a flag that has not been armed by a read leaves the flag unchanged. Writing 1 to any of bits 5..0 never changes a flag.
- R7: Every write uses up all arming. A second write of 0 with no read in between does not clear the flag.
- R8: When an event pulse and a valid clearing write hit the same flag in the same cycle, the flag stays 1.
- R9: A flag that was 0 at the arming read and is set before the write is not cleared by that write.
- R10: When `PHASE_CAPABLE`=0, bit 7 reads 1 and bit 5 reads 0 at all times, whatever `dir_up` and `evt_udf` are. The underflow interrupt request stays 0.
- R11: `irq[i]` is 1 exactly when flag i is 1 and `irq_en[i]` is 1. The index i follows the bit positions given in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Register read strobe; arms the flags that are 1 in this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a 0 in bits 5..0 clears the matching armed flag |
| rd_data | output | 8 | Register readback value |
| dir_up | input | 1 | Counter direction from the timer core (1 = up) |
| evt_udf | input | 1 | Underflow event pulse |
| evt_ovf | input | 1 | Overflow event pulse |
| evt_cmp | input | 4 | Compare/capture event pulses; index 3 is D and index 0 is A |
| irq_en | input | 6 | Per-flag interrupt enables, using the bit positions of R4 |
| irq | output | 6 | Level interrupt requests, using the bit positions of R4 |

## Verification
The hardest situations to reach are the races around the read-then-write handshake. One is an event that sets a flag on the same edge as its clearing write. Another is a flag set between the arming read and the write. A third is a second write that arrives with no read in between. Directed sequences build each of these step by step. After that, a long random run drives reads, writes, write data and event pulses independently on every cycle, so these overlaps also occur in many mixed combinations. A reference model in the bench compares both a phase-capable instance and a reserved-bit instance on every cycle.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_FLAGS = 6;
  localparam int DIR_POS   = 7;
  localparam int FIX1_POS  = 6;
  localparam int UDF_POS   = 5;
  localparam int OVF_POS   = 4;

  // Next value of one sticky flag: a set event always beats a clear.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Read-armed bit: any write consumes it, and a read while the flag is 1 re-arms it.
  function automatic logic arm_next(input logic arm, input logic cur,
                                    input logic rd, input logic wr);
    return (arm & ~wr) | (rd & cur);
  endfunction

  // Assemble the register readback image.
  function automatic logic [REG_W-1:0] pack_status(input logic dir,
                                                   input logic [NUM_FLAGS-1:0] f);
    logic [REG_W-1:0] v;
    v = '0;
    v[NUM_FLAGS-1:0] = f;
    v[FIX1_POS] = 1'b1;
    v[DIR_POS]  = dir;
    return v;
  endfunction
endpackage

// File: rtl/tfr_flag_cell.sv
module tfr_flag_cell #(
  parameter bit ENABLED = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic flag_o,
  output logic arm_o,
  output logic clr_o
);
  import tfr_pkg::*;

  logic flag_q, arm_q, clr_hit;

  // A clear takes effect only with an armed flag and a 0 in the written bit.
  assign clr_hit = wr_stb & ~wr_bit & arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= ENABLED ? flag_next(flag_q, set_pulse, clr_hit) : 1'b0;
      arm_q  <= ENABLED ? arm_next(arm_q, flag_q, rd_stb, wr_stb) : 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;
  assign clr_o  = clr_hit;
endmodule

// File: rtl/tfr_readback.sv
module tfr_readback #(
  parameter bit PHASE_CAPABLE = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dir_up,
  input  logic [tfr_pkg::NUM_FLAGS-1:0] flags,
  output logic [tfr_pkg::REG_W-1:0]     rd_data
);
  import tfr_pkg::*;

  logic dir_q;

  // The direction bit is registered; it is fixed at 1 when the channel cannot phase-count.
  always_ff @(posedge clk) begin
    if (!rst_n) dir_q <= 1'b1;
    else        dir_q <= PHASE_CAPABLE ? dir_up : 1'b1;
  end

  assign rd_data = pack_status(dir_q, flags);
endmodule

// File: rtl/tmr_flag_reg.sv
module tmr_flag_reg #(
  parameter bit PHASE_CAPABLE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       dir_up,
  input  logic       evt_udf,
  input  logic       evt_ovf,
  input  logic [3:0] evt_cmp,
  input  logic [5:0] irq_en,
  output logic [5:0] irq
);
  import tfr_pkg::*;

  // Internal events, brought out as named wires for the checker.
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] arm_q;
  logic [NUM_FLAGS-1:0] clr_hit;

  assign set_vec = {evt_udf & PHASE_CAPABLE, evt_ovf, evt_cmp};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    localparam bit CELL_ON = (i == UDF_POS) ? PHASE_CAPABLE : 1'b1;
    tfr_flag_cell #(.ENABLED(CELL_ON)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pulse (set_vec[i]),
      .rd_stb    (rd_en),
      .wr_stb    (wr_en),
      .wr_bit    (wr_data[i]),
      .flag_o    (flag_q[i]),
      .arm_o     (arm_q[i]),
      .clr_o     (clr_hit[i])
    );
  end

  tfr_readback #(.PHASE_CAPABLE(PHASE_CAPABLE)) u_rb (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir_up  (dir_up),
    .flags   (flag_q),
    .rd_data (rd_data)
  );

  assign irq = flag_q & irq_en;

  logic unused_wr_hi;
  assign unused_wr_hi = &{1'b1, wr_data[7:6]};
endmodule

// File: rtl/tfr_chk.sv
module tfr_chk #(
  parameter bit PHASE_CAPABLE = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       wr_en,
  input logic       dir_up,
  input logic [7:0] rd_data,
  input logic [5:0] irq_en,
  input logic [5:0] irq,
  input logic [5:0] set_vec,
  input logic [5:0] flag_q,
  input logic [5:0] arm_q,
  input logic [5:0] clr_hit
);
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 6'h0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  // R5
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_hit & ~set_vec) != 6'h0) |=> ((flag_q & $past(clr_hit & ~set_vec)) == 6'h0));

  // R6
  unarmed_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~arm_q) != 6'h0) |=> ((flag_q & $past(flag_q & ~arm_q)) == $past(flag_q & ~arm_q)));

  // R7
  write_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((arm_q & ~$past(flag_q & {6{rd_en}})) == 6'h0));

  // R2
  fixed_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_data[6]);

  // R3
  dir_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    PHASE_CAPABLE |=> (rd_data[7] == $past(dir_up)));

  // R10
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !PHASE_CAPABLE |-> (rd_data[7] && !rd_data[5] && !irq[5]));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~irq_en) == 6'h0) && (irq == (rd_data[5:0] & irq_en)));
endmodule

bind tmr_flag_reg tfr_chk #(.PHASE_CAPABLE(PHASE_CAPABLE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .dir_up  (dir_up),
  .rd_data (rd_data),
  .irq_en  (irq_en),
  .irq     (irq),
  .set_vec (set_vec),
  .flag_q  (flag_q),
  .arm_q   (arm_q),
  .clr_hit (clr_hit)
);

// File: tb/tmr_flag_reg_test.sv
module tmr_flag_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0, dir_up = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic       evt_udf = 1'b0, evt_ovf = 1'b0;
  logic [3:0] evt_cmp = 4'h0;
  logic [5:0] irq_en = 6'h00;
  logic [7:0] rd_p, rd_r;
  logic [5:0] irq_p, irq_r;

  int checks = 0;
  int fails  = 0;

  // Model state: phase-capable channel (m*) and reserved-bit channel (r*).
  logic [5:0] mf = 6'h0, ma = 6'h0, rf = 6'h0, ra = 6'h0;
  logic       md = 1'b1;

  always #4 clk = ~clk;

  tmr_flag_reg #(.PHASE_CAPABLE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_p), .dir_up(dir_up), .evt_udf(evt_udf), .evt_ovf(evt_ovf),
    .evt_cmp(evt_cmp), .irq_en(irq_en), .irq(irq_p));

  tmr_flag_reg #(.PHASE_CAPABLE(1'b0)) uut_rsv (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_r), .dir_up(dir_up), .evt_udf(evt_udf), .evt_ovf(evt_ovf),
    .evt_cmp(evt_cmp), .irq_en(irq_en), .irq(irq_r));

  // Flags after one edge: a set pulse survives; a 0 written to a read-armed bit drops.
  function automatic logic [5:0] exp_flags(input logic [5:0] f, input logic [5:0] a,
                                           input logic [5:0] s, input logic w,
                                           input logic [7:0] d);
    logic [5:0] kill;
    kill = w ? (a & ~d[5:0]) : 6'h00;
    return (f & ~kill) | s;
  endfunction

  function automatic logic [5:0] exp_arm(input logic [5:0] f, input logic [5:0] a,
                                         input logic r, input logic w);
    logic [5:0] keep;
    keep = w ? 6'h00 : a;
    return r ? (keep | f) : keep;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [7:0] d,
                      input logic dir, input logic [5:0] s, input logic [5:0] en);
    logic [5:0] nmf, nma, nrf, nra;
    @(negedge clk);
    rd_en = r; wr_en = w; wr_data = d; dir_up = dir;
    evt_udf = s[5]; evt_ovf = s[4]; evt_cmp = s[3:0]; irq_en = en;
    #1;
    chk("R4 R5 readback", rd_p, {md, 1'b1, mf});
    chk("R11 irq", {2'b00, irq_p}, {2'b00, mf & en});
    chk("R10 readback", rd_r, {1'b1, 1'b1, rf});
    chk("R10 irq", {2'b00, irq_r}, {2'b00, rf & en});
    nmf = exp_flags(mf, ma, s, w, d);
    nma = exp_arm(mf, ma, r, w);
    nrf = exp_flags(rf, ra, s & 6'h1F, w, d);
    nra = exp_arm(rf, ra, r, w);
    @(posedge clk);
    #1;
    mf = nmf; ma = nma; rf = nrf; ra = nra; md = dir;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 8'hFF, 1'b1, 6'h00, 6'h00);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset image on both variants
    chk("R1 reset phase", rd_p, 8'hC0);
    chk("R1 reset rsv", rd_r, 8'hC0);
    chk("R1 irq", {2'b00, irq_p}, 8'h00);
    idle(2);

    // R4: overflow pulse sets bit 4
    step(0, 0, 8'hFF, 1, 6'h10, 6'h00);
    chk("R4 ovf set", rd_p, 8'hD0);
    // R6: write 0 without an arming read
    step(0, 1, 8'h00, 1, 6'h00, 6'h00);
    chk("R6 unarmed write", rd_p, 8'hD0);
    // R6: writing 1 after arming does not clear; R7: that write used the arming up
    step(1, 0, 8'hFF, 1, 6'h00, 6'h00);
    step(0, 1, 8'hFF, 1, 6'h00, 6'h00);
    chk("R6 write one", rd_p, 8'hD0);
    step(0, 1, 8'h00, 1, 6'h00, 6'h00);
    chk("R7 consumed", rd_p, 8'hD0);
    // R5: read then write 0 clears
    step(1, 0, 8'hFF, 1, 6'h00, 6'h00);
    step(0, 1, 8'h00, 1, 6'h00, 6'h00);
    chk("R5 clear", rd_p, 8'hC0);
    // R8: set beats a simultaneous valid clear on flag A
    step(0, 0, 8'hFF, 1, 6'h01, 6'h00);
    step(1, 0, 8'hFF, 1, 6'h00, 6'h00);
    step(0, 1, 8'h00, 1, 6'h01, 6'h00);
    chk("R8 set wins", rd_p, 8'hC1);
    step(1, 0, 8'hFF, 1, 6'h00, 6'h00);
    step(0, 1, 8'hFE, 1, 6'h00, 6'h00);
    chk("R5 clear A", rd_p, 8'hC0);
    // R9: flag B set after the read is kept
    step(1, 0, 8'hFF, 1, 6'h00, 6'h00);
    step(0, 0, 8'hFF, 1, 6'h02, 6'h00);
    step(0, 1, 8'h00, 1, 6'h00, 6'h00);
    chk("R9 late set kept", rd_p, 8'hC2);
    step(1, 0, 8'hFF, 1, 6'h00, 6'h00);
    step(0, 1, 8'h00, 1, 6'h00, 6'h00);
    // R3: direction follows dir_up; R10: reserved channel ignores it
    step(0, 0, 8'hFF, 0, 6'h00, 6'h00);
    chk("R3 dir down", rd_p, 8'h40);
    chk("R10 dir fixed", rd_r, 8'hC0);
    // R4/R10: underflow sets bit 5 only on the phase-capable channel
    step(0, 0, 8'hFF, 0, 6'h20, 6'h00);
    chk("R4 udf set", rd_p, 8'h60);
    chk("R10 udf fixed", rd_r, 8'hC0);
    // R11: enable gates the request; R10: reserved underflow never requests
    step(0, 0, 8'hFF, 0, 6'h00, 6'h3F);
    chk("R11 irq udf", {2'b00, irq_p}, 8'h20);
    chk("R10 irq udf", {2'b00, irq_r}, 8'h00);
    step(0, 0, 8'hFF, 0, 6'h00, 6'h1F);
    chk("R11 irq masked", {2'b00, irq_p}, 8'h00);
    // R2: bit 6 survives a write of 0
    step(1, 0, 8'hFF, 0, 6'h00, 6'h00);
    step(0, 1, 8'h00, 0, 6'h00, 6'h00);
    chk("R2 fixed one", {7'b0, rd_p[6]}, 8'h01);
    chk("R5 udf clear", rd_p, 8'h40);

    // Random mix: reads, writes, events and enables all drawn independently.
    for (int n = 0; n < 3000; n++) begin
      logic r, w, dir;
      logic [7:0] d;
      logic [5:0] s, en;
      r   = ($urandom % 2) == 0;
      w   = ($urandom % 3) == 0;
      d   = 8'($urandom);
      dir = 1'($urandom);
      s   = 6'($urandom) & 6'($urandom) & 6'($urandom);
      en  = 6'($urandom);
      step(r, w, d, dir, s, en);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule